// File: doc/BRIEF.md
# SDRAM Command Timing Sequencer

This block runs the command sequence for one SDRAM access: ACTIVATE to open the row, then READ or WRITE at the column, then PRECHARGE to close the row. A request carries a direction, a row address and a column address, and is taken over a valid/ready handshake. The block drives the active-low command lines (chip select, RAS, CAS, WE), the address bus, a select line for an external row/column address multiplexer and a strobe that marks the cycle in which read data is to be captured.

Four configuration inputs set the timing, and all four are latched at acceptance.
- An address-mux delay enable adds a lead-in cycle to each address phase. This suits boards where an external multiplexer or address buffer slows the address lines.
- A buffered-command enable holds every command for two cycles, with chip select low in the first cycle only. This suits boards with external buffers on the command lines.
- A two-bit CAS latency code sets how many cycles pass between the read command and the capture strobe.
- A programmable activate-to-read/write delay sets the spacing between ACTIVATE and the column command.

Between commands the bus sits at NOP. Ready returns once the PRECHARGE has been issued.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Out of reset, and whenever the block is idle, all four command lines are high (NOP), addr is 0, muxSel and rdCapture are 0, and reqReady is 1 as long as cfgCasLat is not 00.
- R2: While cfgCasLat is 00, reqReady is 0 and cfgErr is 1, no request is accepted and no command is issued. cfgErr is 0 for any other code.
- R3: The command encodings on {csN,rasN,casN,weN} are: NOP 1111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010. ACTIVATE drives the row on addr. READ and WRITE drive the column on addr, zero-extended. PRECHARGE and plain NOP cycles drive addr to 0.
- R4: With the mux enable at 0, ACTIVATE is issued in the first cycle after acceptance and muxSel stays 0 for the whole access.
- R5: With the mux enable at 1, one NOP cycle with muxSel=1 and the row on addr comes before ACTIVATE, and muxSel stays 1 during the ACTIVATE cycles. One NOP cycle with muxSel=0 and the column on addr comes immediately before READ/WRITE.
- R6: READ/WRITE starts D cycles after ACTIVATE starts. D is the largest of three values: the programmed delay; 2 with the mux enable set, or 1 without it; and the command length plus the mux lead-in.
- R7: With the buffered-command enable at 1, every command holds RAS, CAS, WE and addr for two cycles, and csN is low in the first cycle only. With it at 0, each command lasts one cycle.
- R8: For a read, rdCapture pulses for exactly one cycle, CL cycles after the first READ cycle. Codes 01, 10 and 11 give CL of 1, 2 and 3. rdCapture never pulses during a write.
- R9: PRECHARGE starts in the cycle after the last WRITE cycle, or in the cycle after the capture pulse for a read. reqReady returns to 1 in the cycle after PRECHARGE ends.
- R10: Direction, addresses and configuration are taken only at acceptance. Changing any of them during an access does not alter that access.
- R11: While an access is in progress reqReady is 0, and a held reqValid neither restarts nor disturbs the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Column address |
| cfgMuxDelay | input | 1 | Add an address-phase lead-in cycle |
| cfgBufCmd | input | 1 | Hold commands for two cycles |
| cfgCasLat | input | 2 | CAS latency code (00 invalid) |
| cfgActToRw | input | DLY_W | Programmed activate-to-read/write delay |
| cfgErr | output | 1 | Invalid CAS latency code present |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | max(ROW_W,COL_W) | SDRAM address bus |
| muxSel | output | 1 | External address mux select (row phase) |
| rdCapture | output | 1 | Read-data capture strobe |

## Verification
The hardest case to reach is one where several timing rules compete for the same cycle. Examples are a buffered command whose second cycle coincides with the mux lead-in, a programmed delay that the mux floor or the command length overrides, and a one-cycle CAS latency whose capture pulse lands inside a held READ.

The stimulus table sets each of these combinations on purpose. The bench then compares every cycle of the access against a cycle model built from the requirements. Two directed accesses flip all request and configuration inputs, or hold reqValid, right after acceptance, so that any late sampling of the inputs shows up in the trace.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE
  } cmd_e;

  typedef enum logic [1:0] {
    ADR_ZERO,
    ADR_ROW,
    ADR_COL
  } adrSel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROWLEAD,
    ST_ROW,
    ST_COL,
    ST_PRE
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;
    cmd_e    cmd;
    logic    csOn;
    adrSel_e adrSel;
    logic    muxOn;
    logic    capture;
  } seqStrobe_t;

  // configuration latched at acceptance
  typedef struct packed {
    logic       isWrite;
    logic       muxDelay;
    logic       bufCmd;
    logic [1:0] casLat;
  } seqCfg_t;

endpackage

// File: rtl/sdram_seq_dp.sv
module sdram_seq_dp
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DLY_W  = 4,
  parameter int ADDR_W = 13,
  parameter int RCD_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              reqWrite,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              cfgMuxDelay,
  input  logic              cfgBufCmd,
  input  logic [1:0]        cfgCasLat,
  input  logic [DLY_W-1:0]  cfgActToRw,
  output seqCfg_t           latCfg,
  output logic [RCD_W-1:0]  latRcd,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic              muxSel,
  output logic              rdCapture
);

  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ;
  logic [RCD_W-1:0] dlyExt, floorVal, minVal, dlyFloored, rcdNext;

  // effective activate-to-column spacing, computed from the live inputs
  always_comb begin
    dlyExt     = RCD_W'(cfgActToRw);
    floorVal   = cfgMuxDelay ? RCD_W'(2) : RCD_W'(1);
    dlyFloored = (dlyExt < floorVal) ? floorVal : dlyExt;
    minVal     = (cfgBufCmd ? RCD_W'(2) : RCD_W'(1)) + RCD_W'(cfgMuxDelay);
    rcdNext    = (dlyFloored < minVal) ? minVal : dlyFloored;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ   <= '0;
      colQ   <= '0;
      latCfg <= '0;
      latRcd <= RCD_W'(1);
    end else if (strobe.load) begin
      rowQ           <= reqRow;
      colQ           <= reqCol;
      latCfg.isWrite <= reqWrite;
      latCfg.muxDelay <= cfgMuxDelay;
      latCfg.bufCmd  <= cfgBufCmd;
      latCfg.casLat  <= cfgCasLat;
      latRcd         <= rcdNext;
    end
  end

  // pin decode
  always_comb begin
    unique case (strobe.cmd)
      CMD_ACT: {rasN, casN, weN} = 3'b011;
      CMD_RD:  {rasN, casN, weN} = 3'b101;
      CMD_WR:  {rasN, casN, weN} = 3'b100;
      CMD_PRE: {rasN, casN, weN} = 3'b010;
      default: {rasN, casN, weN} = 3'b111;
    endcase
    csN = !(strobe.csOn && (strobe.cmd != CMD_NOP));
    unique case (strobe.adrSel)
      ADR_ROW: addr = ADDR_W'(rowQ);
      ADR_COL: addr = ADDR_W'(colQ);
      default: addr = '0;
    endcase
    muxSel    = strobe.muxOn;
    rdCapture = strobe.capture;
  end

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int RCD_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       cfgCasLat,
  input  logic             cfgMuxDelay,
  input  seqCfg_t          latCfg,
  input  logic [RCD_W-1:0] latRcd,
  output logic             reqReady,
  output logic             cfgErr,
  output seqStrobe_t       strobe
);

  seqState_e        state, stateNext;
  logic [CNT_W-1:0] el, elNext;
  logic [CNT_W-1:0] cmdLen, rcdLast, colEnd, colLast, preLast;
  logic             inCmd, accept;

  always_comb begin
    cmdLen  = latCfg.bufCmd ? CNT_W'(2) : CNT_W'(1);
    rcdLast = CNT_W'(latRcd) - CNT_W'(1);
    colEnd  = latCfg.isWrite ? cmdLen : (CNT_W'(latCfg.casLat) + CNT_W'(1));
    colLast = colEnd - CNT_W'(1);
    preLast = cmdLen - CNT_W'(1);
    inCmd   = (el < cmdLen);
  end

  assign cfgErr   = (cfgCasLat == 2'b00);
  assign reqReady = (state == ST_IDLE) && !cfgErr;
  assign accept   = reqValid && reqReady;

  // next state
  always_comb begin
    stateNext = state;
    elNext    = el + CNT_W'(1);
    unique case (state)
      ST_IDLE: begin
        elNext = '0;
        if (accept) stateNext = cfgMuxDelay ? ST_ROWLEAD : ST_ROW;
      end
      ST_ROWLEAD: begin
        elNext    = '0;
        stateNext = ST_ROW;
      end
      ST_ROW: begin
        if (el == rcdLast) begin
          stateNext = ST_COL;
          elNext    = '0;
        end
      end
      ST_COL: begin
        if (el == colLast) begin
          stateNext = ST_PRE;
          elNext    = '0;
        end
      end
      ST_PRE: begin
        if (el == preLast) begin
          stateNext = ST_IDLE;
          elNext    = '0;
        end
      end
      default: begin
        stateNext = ST_IDLE;
        elNext    = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      el    <= '0;
    end else begin
      state <= stateNext;
      el    <= elNext;
    end
  end

  // strobes
  always_comb begin
    strobe         = '0;
    strobe.cmd     = CMD_NOP;
    strobe.adrSel  = ADR_ZERO;
    strobe.load    = (state == ST_IDLE) && accept;
    unique case (state)
      ST_ROWLEAD: begin
        strobe.adrSel = ADR_ROW;
        strobe.muxOn  = 1'b1;
      end
      ST_ROW: begin
        if (inCmd) begin
          strobe.cmd    = CMD_ACT;
          strobe.csOn   = (el == '0);
          strobe.adrSel = ADR_ROW;
          strobe.muxOn  = latCfg.muxDelay;
        end else if (latCfg.muxDelay && (el == rcdLast)) begin
          strobe.adrSel = ADR_COL;
        end
      end
      ST_COL: begin
        if (inCmd) begin
          strobe.cmd    = latCfg.isWrite ? CMD_WR : CMD_RD;
          strobe.csOn   = (el == '0);
          strobe.adrSel = ADR_COL;
        end
        strobe.capture = !latCfg.isWrite && (el == CNT_W'(latCfg.casLat));
      end
      ST_PRE: begin
        strobe.cmd  = CMD_PRE;
        strobe.csOn = (el == '0);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int DLY_W = 4
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    reqValid,
  output logic                                    reqReady,
  input  logic                                    reqWrite,
  input  logic [ROW_W-1:0]                        reqRow,
  input  logic [COL_W-1:0]                        reqCol,
  input  logic                                    cfgMuxDelay,
  input  logic                                    cfgBufCmd,
  input  logic [1:0]                              cfgCasLat,
  input  logic [DLY_W-1:0]                        cfgActToRw,
  output logic                                    cfgErr,
  output logic                                    csN,
  output logic                                    rasN,
  output logic                                    casN,
  output logic                                    weN,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] addr,
  output logic                                    muxSel,
  output logic                                    rdCapture
);

  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int RCD_W  = DLY_W + 1;
  localparam int CNT_W  = RCD_W + 1;

  seqStrobe_t       strobe;
  seqCfg_t          latCfg;
  logic [RCD_W-1:0] latRcd;

  sdram_seq_ctrl #(.RCD_W(RCD_W), .CNT_W(CNT_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .cfgCasLat  (cfgCasLat),
    .cfgMuxDelay(cfgMuxDelay),
    .latCfg     (latCfg),
    .latRcd     (latRcd),
    .reqReady   (reqReady),
    .cfgErr     (cfgErr),
    .strobe     (strobe)
  );

  sdram_seq_dp #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DLY_W(DLY_W), .ADDR_W(ADDR_W), .RCD_W(RCD_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqWrite   (reqWrite),
    .reqRow     (reqRow),
    .reqCol     (reqCol),
    .cfgMuxDelay(cfgMuxDelay),
    .cfgBufCmd  (cfgBufCmd),
    .cfgCasLat  (cfgCasLat),
    .cfgActToRw (cfgActToRw),
    .latCfg     (latCfg),
    .latRcd     (latRcd),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .addr       (addr),
    .muxSel     (muxSel),
    .rdCapture  (rdCapture)
  );

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        cfgCasLat,
  input logic              cfgErr,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [ADDR_W-1:0] addr,
  input logic              muxSel,
  input logic              rdCapture
);

  logic anyCmd;
  assign anyCmd = !(rasN && casN && weN);

  // R1: an idle sequencer leaves the bus at NOP
  assert_idle_nop_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (csN && !anyCmd && !muxSel && !rdCapture && (addr == '0)));

  // R2: invalid latency code refuses requests
  assert_bad_cl_refused_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCasLat == 2'b00) |-> (!reqReady && cfgErr));

  // R3: column commands carry a zero-extended column
  assert_col_zero_ext_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && rasN) |-> ((addr >> COL_W) == '0));

  // R5: mux select never overlaps a column command
  assert_mux_row_only_R5: assert property (@(posedge clk) disable iff (!rstN)
    muxSel |-> casN);

  // R7: a command cycle with chip select high continues the previous command
  assert_held_cmd_R7: assert property (@(posedge clk) disable iff (!rstN)
    (csN && anyCmd) |-> (!$past(csN) && $stable(rasN) && $stable(casN)
                         && $stable(weN) && $stable(addr)));

  // R9: precharge follows the capture pulse
  assert_pre_after_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdCapture |=> (!csN && !rasN && casN && !weN));

  // R11: an accepted request drops ready
  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

bind sdram_cmd_seq sdram_seq_chk #(.ADDR_W(ADDR_W), .COL_W(COL_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .cfgCasLat(cfgCasLat),
  .cfgErr   (cfgErr),
  .csN      (csN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .addr     (addr),
  .muxSel   (muxSel),
  .rdCapture(rdCapture)
);

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 13;
  localparam int COL_W = 10;
  localparam int DLY_W = 4;
  localparam int ADDR_W = 13;
  localparam int NVEC = 10;

  // {expected busy cycles[4:0], write, mux, bufCmd, cl[1:0], delay[3:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {5'd5,  1'b0, 1'b0, 1'b0, 2'd2, 4'd1},
    {5'd5,  1'b1, 1'b0, 1'b0, 2'd2, 4'd3},
    {5'd8,  1'b0, 1'b1, 1'b0, 2'd3, 4'd1},
    {5'd8,  1'b1, 1'b1, 1'b1, 2'd1, 4'd0},
    {5'd6,  1'b0, 1'b0, 1'b1, 2'd1, 4'd0},
    {5'd12, 1'b0, 1'b1, 1'b1, 2'd3, 4'd5},
    {5'd6,  1'b1, 1'b0, 1'b1, 2'd2, 4'd2},
    {5'd18, 1'b0, 1'b0, 1'b0, 2'd1, 4'd15},
    {5'd5,  1'b1, 1'b1, 1'b0, 2'd3, 4'd2},
    {5'd6,  1'b0, 1'b0, 1'b0, 2'd3, 4'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic cfgMuxDelay = 1'b0;
  logic cfgBufCmd = 1'b0;
  logic [1:0] cfgCasLat = 2'd2;
  logic [DLY_W-1:0] cfgActToRw = '0;
  logic cfgErr, csN, rasN, casN, weN, muxSel, rdCapture;
  logic [ADDR_W-1:0] addr;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DLY_W(DLY_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqRow(reqRow), .reqCol(reqCol),
    .cfgMuxDelay(cfgMuxDelay), .cfgBufCmd(cfgBufCmd), .cfgCasLat(cfgCasLat),
    .cfgActToRw(cfgActToRw), .cfgErr(cfgErr), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .addr(addr), .muxSel(muxSel), .rdCapture(rdCapture)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nFails = nFails + 1;
      nChecks = nChecks + 1;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks = nChecks + 1;
    if (got !== exp) begin
      nFails = nFails + 1;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // cycle model: t is the sample index after the accepting edge (0-based)
  task automatic modelAt(input int t, input bit w, input bit m, input bit b,
                         input int cl, input int d,
                         input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                         output logic [3:0] ctl, output logic [ADDR_W-1:0] ad,
                         output logic mx, output logic cap, output logic rdy,
                         output string tag, output int total);
    int len, lead, flo, deff, rcd, colEnd, a, b2, p;
    len = b ? 2 : 1;
    lead = m ? 1 : 0;
    flo = m ? 2 : 1;
    deff = (d < flo) ? flo : d;
    rcd = (deff < len + lead) ? len + lead : deff;
    colEnd = w ? len : cl + 1;
    total = lead + rcd + colEnd + len;
    ctl = 4'b1111; ad = '0; mx = 1'b0; cap = 1'b0; rdy = 1'b0; tag = "R1";
    if (t >= total) begin
      rdy = 1'b1; tag = "R9";
    end else if (m && t == 0) begin
      mx = 1'b1; ad = ADDR_W'(row); tag = "R5";
    end else begin
      a = t - lead;
      if (a < rcd) begin
        if (a < len) begin
          ctl = {(a == 0) ? 1'b0 : 1'b1, 3'b011};
          ad = ADDR_W'(row); mx = m;
          tag = (a == 0) ? (m ? "R5" : "R4") : "R7";
        end else if (m && a == rcd - 1) begin
          ad = ADDR_W'(col); tag = "R5";
        end else tag = "R6";
      end else begin
        b2 = a - rcd;
        if (b2 < colEnd) begin
          if (b2 < len) begin
            ctl = {(b2 == 0) ? 1'b0 : 1'b1, 2'b10, w ? 1'b0 : 1'b1};
            ad = ADDR_W'(col);
            tag = (b2 == 0) ? "R3" : "R7";
          end else tag = "R8";
          cap = !w && (b2 == cl);
          if (cap) tag = "R8";
        end else begin
          p = b2 - colEnd;
          ctl = {(p == 0) ? 1'b0 : 1'b1, 3'b010};
          tag = "R9";
        end
      end
    end
  endtask

  task automatic runAccess(input bit w, input bit m, input bit b, input int cl,
                           input int d, input logic [ROW_W-1:0] row,
                           input logic [COL_W-1:0] col, input int expBusy,
                           input bit changeMid, input bit holdValid, input string over);
    logic [3:0] ctl; logic [ADDR_W-1:0] ad; logic mx, cap, rdy;
    string tag; int total; int busy;
    @(negedge clk);
    reqWrite = w; cfgMuxDelay = m; cfgBufCmd = b; cfgCasLat = 2'(cl);
    cfgActToRw = DLY_W'(d); reqRow = row; reqCol = col; reqValid = 1'b1;
    check("R1 ready before access", {31'd0, reqReady}, 32'd1);
    busy = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (k == 0) begin
        if (!holdValid) reqValid = 1'b0;
        if (changeMid) begin
          reqWrite = !w; cfgMuxDelay = !m; cfgBufCmd = !b;
          cfgCasLat = (cl == 3) ? 2'd1 : 2'(cl + 1);
          cfgActToRw = ~DLY_W'(d); reqRow = ~row; reqCol = ~col;
        end
      end
      modelAt(k, w, m, b, cl, d, row, col, ctl, ad, mx, cap, rdy, tag, total);
      if (over != "") tag = over;
      check(tag, {13'd0, csN, rasN, casN, weN, addr, muxSel, rdCapture, reqReady},
                 {13'd0, ctl, ad, mx, cap, rdy});
      if (!reqReady) busy++;
      if (k >= total) break;
    end
    reqValid = 1'b0;
    check("R9 busy cycle count", 32'(busy), 32'(expBusy));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {26'd0, csN, rasN, casN, weN, muxSel, rdCapture},
                              {26'd0, 4'b1111, 2'b00});
    check("R1 reset addr", 32'(addr), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle ready", {30'd0, reqReady, cfgErr}, {30'd0, 2'b10});

    // R2: reserved latency code
    cfgCasLat = 2'b00; reqValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 refused with code 00", {29'd0, reqReady, cfgErr, csN}, {29'd0, 3'b011});
    end
    cfgCasLat = 2'd2;
    #1;
    check("R2 code restored", {30'd0, reqReady, cfgErr}, {30'd0, 2'b10});
    reqValid = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      runAccess(VEC[i][8], VEC[i][7], VEC[i][6], int'(VEC[i][5:4]), int'(VEC[i][3:0]),
                ROW_W'(13'h0A5 + 13'(i * 293)), COL_W'(10'h05A + 10'(i * 71)),
                int'(VEC[i][13:9]), 1'b0, 1'b0, "");
    end

    // R10: every input flipped right after acceptance
    runAccess(1'b0, 1'b1, 1'b0, 2, 3, 13'h1234, 10'h2CD, 8, 1'b1, 1'b0, "R10");
    runAccess(1'b1, 1'b0, 1'b1, 1, 0, 13'h0F0F, 10'h155, 6, 1'b1, 1'b0, "R10");
    // R11: reqValid held high for the whole access
    runAccess(1'b0, 1'b0, 1'b1, 3, 4, 13'h1ABC, 10'h3FF, 10, 1'b0, 1'b1, "R11");
    runAccess(1'b1, 1'b1, 1'b1, 2, 1, 13'h1FFF, 10'h001, 8, 1'b1, 1'b1, "R11");

    @(negedge clk);
    check("R1 idle after all", {28'd0, csN, rasN, casN, weN}, {28'd0, 4'b1111});
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule